// File: doc/BRIEF.md
# Grid-Multiplexed Serial Display Shifter

This block feeds an external vacuum-fluorescent display driver through a three-wire serial link plus a blanking line. It walks a fixed number of grids in equal timeslots. In each timeslot it sends the bit image for the grid that comes next, one bit per two clock cycles, and then pulses a load strobe so the driver latches that image when the slot changes. The stream length is set at run time. A limit value above the largest legal index is clamped.

Each position in the stream is routed through a small map RAM. The map holds one 7-bit code per position. The code picks one bit from a 128-bit source vector. That vector holds the segment bits for the grid being sent, then a one-hot grid-select field, then constant zeros. The segment bits come from a simple bus: the block shows the index of the grid it needs on `seg_grid`, and the host answers on `seg_data`. The stream runs freely at display timing. It has no handshake and no back-pressure. The host must keep `seg_data` valid for `seg_grid` by the first cycle of each timeslot, because the block captures it in that cycle. A blanking output dims the display at the end of every slot so the phosphor can decay before the grid switches.

Top module: `vfd_mux_shifter`

## Requirements
- R1: Each timeslot lasts SLOT_CYCLES (400) clock cycles. Timeslots visit grids 0 to NUM_GRIDS-1 in order and then wrap. `seg_grid` names the grid whose data is shifted in the current slot, which is the current grid plus one, modulo NUM_GRIDS.
- R2: `vfd_sclk` has a bit period of two cycles: one cycle low, then one cycle high. It stays low whenever no bit is being shifted.
- R3: `vfd_dout` changes only while `vfd_sclk` is low, so it is stable across each rising edge. It is low outside the shift window.
- R4: Each timeslot carries exactly M+1 bits, where M is the shift limit in effect at the start of that slot.
- R5: The shift limit is written through `lim_we`/`lim_val`. A written value from 0x7A to 0xFF is stored as 0x79. The value after reset is 0x79. A write takes effect from the next timeslot.
- R6: Stream bit i equals source[map[i]]. Source indices 0 to SEG_W-1 are the `seg_data` bits captured at slot start. Index SEG_W+g is 1 only when g is the grid being shifted. All higher indices are 0, and code 0x7F always gives 0. Map entries reset to 0x7F and are written through `map_we`/`map_addr`/`map_code`.
- R7: `vfd_blank` is high for the last BLANK_CYCLES (25) cycles of each timeslot and low for the rest.
- R8: `vfd_load` is high for exactly two cycles once per timeslot. The pulse starts in the second cycle of the blank window, after the last bit.
- R9: While reset is asserted and right after it, `vfd_sclk`, `vfd_dout`, `vfd_load` and `vfd_blank` are low and `seg_grid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Map RAM write enable |
| map_addr | input | 7 | Stream position to write |
| map_code | input | 7 | Source code for that position |
| lim_we | input | 1 | Shift-limit write enable |
| lim_val | input | 8 | Shift-limit value (clamped) |
| seg_grid | output | 3 | Grid whose segment data is requested |
| seg_data | input | 40 | Segment bits for `seg_grid` |
| vfd_sclk | output | 1 | Serial clock to the driver |
| vfd_dout | output | 1 | Serial data to the driver |
| vfd_load | output | 1 | Latch strobe to the driver |
| vfd_blank | output | 1 | Blanking output, active high |

## Verification
On every cycle the assertions check the pin-level rules. The serial clock is high for single cycles only. Data holds steady while the clock is high. The blank window is free of clock and data, and the load strobe is two cycles wide inside it. They also check that the stored limit never exceeds the clamp value and that the grid steps by one at each slot boundary. Only the bench scenarios can show what the stream carries: the bit count for each limit setting, the value of every mapped bit against the programmed codes and segment patterns, the grid order across slots, the exact blank and load placement, and the restored map and limit after a reset in mid-run.

// File: rtl/vfd_mux_pkg.sv
package vfd_mux_pkg;
  localparam int CODE_W   = 7;
  localparam int SRC_W    = 1 << CODE_W;
  localparam logic [CODE_W-1:0] CODE_OFF = {CODE_W{1'b1}};

  typedef struct packed {
    logic sclk;
    logic dout;
    logic load;
    logic blank;
  } vfd_pins_t;
endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
  parameter int SLOT_CYCLES = 400,
  parameter int NUM_GRIDS   = 8,
  parameter int CNT_W       = 9,
  parameter int GRID_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [CNT_W-1:0]  slot_cnt,
  output logic [GRID_W-1:0] cur_grid,
  output logic [GRID_W-1:0] nxt_grid,
  output logic              slot_first
);
  localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(SLOT_CYCLES - 1);
  localparam logic [GRID_W-1:0] LAST_GRID = GRID_W'(NUM_GRIDS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt <= '0;
      cur_grid <= '0;
    end else if (slot_cnt == LAST_CNT) begin
      slot_cnt <= '0;
      cur_grid <= nxt_grid;
    end else begin
      slot_cnt <= slot_cnt + CNT_W'(1);
    end
  end

  always_comb begin
    nxt_grid   = (cur_grid == LAST_GRID) ? '0 : cur_grid + GRID_W'(1);
    slot_first = (slot_cnt == '0);
  end

  AST_GRID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cnt == LAST_CNT) |=> (cur_grid == (($past(cur_grid) == LAST_GRID) ? '0 : $past(cur_grid) + GRID_W'(1)))); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt <= LAST_CNT); // R1
endmodule

// File: rtl/vfd_map_ram.sv
module vfd_map_ram
  import vfd_mux_pkg::*;
#(
  parameter int DEPTH = 122,
  parameter int AW    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [AW-1:0]     rd_addr,
  output logic [CODE_W-1:0] rd_code
);
  localparam logic [AW:0] DEPTH_X = (AW+1)'(DEPTH);

  logic [CODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CODE_OFF;
    end else if (wr_en && ({1'b0, wr_addr} < DEPTH_X)) begin
      mem[wr_addr] <= wr_code;
    end
  end

  always_comb begin
    if ({1'b0, rd_addr} < DEPTH_X) rd_code = mem[rd_addr];
    else                            rd_code = CODE_OFF;
  end
endmodule

// File: rtl/vfd_src_select.sv
module vfd_src_select
  import vfd_mux_pkg::*;
#(
  parameter int SEG_W     = 40,
  parameter int NUM_GRIDS = 8
) (
  input  logic [SEG_W-1:0]     seg_hold,
  input  logic [NUM_GRIDS-1:0] grid_hot,
  input  logic [CODE_W-1:0]    code,
  output logic                 bit_out
);
  logic [SRC_W-1:0] src;

  for (genvar k = 0; k < SRC_W; k++) begin : g_src
    if (k < SEG_W) begin : g_seg
      assign src[k] = seg_hold[k];
    end else if (k < SEG_W + NUM_GRIDS) begin : g_grid
      assign src[k] = grid_hot[k - SEG_W];
    end else begin : g_zero
      assign src[k] = 1'b0;
    end
  end

  always_comb begin
    bit_out = (code == CODE_OFF) ? 1'b0 : src[code];
  end
endmodule

// File: rtl/vfd_mux_shifter.sv
module vfd_mux_shifter
  import vfd_mux_pkg::*;
#(
  parameter int NUM_GRIDS    = 8,
  parameter int SEG_W        = 40,
  parameter int SLOT_CYCLES  = 400,
  parameter int BLANK_CYCLES = 25,
  parameter int MAX_BITS     = 122,
  parameter int LIM_W        = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         map_we,
  input  logic [$clog2(MAX_BITS)-1:0]  map_addr,
  input  logic [CODE_W-1:0]            map_code,
  input  logic                         lim_we,
  input  logic [LIM_W-1:0]             lim_val,
  output logic [$clog2(NUM_GRIDS)-1:0] seg_grid,
  input  logic [SEG_W-1:0]             seg_data,
  output logic                         vfd_sclk,
  output logic                         vfd_dout,
  output logic                         vfd_load,
  output logic                         vfd_blank
);
  // Shift window must end before the blank window: 2*MAX_BITS+2 < SLOT_CYCLES-BLANK_CYCLES.
  localparam int CNT_W       = $clog2(SLOT_CYCLES);
  localparam int GRID_W      = $clog2(NUM_GRIDS);
  localparam int AW          = $clog2(MAX_BITS);
  localparam int SHIFT_START = 2;
  localparam int BLANK_START = SLOT_CYCLES - BLANK_CYCLES;
  localparam int LOAD_START  = BLANK_START + 1;
  localparam logic [LIM_W-1:0] LIM_MAX = LIM_W'(MAX_BITS - 1);

  logic [CNT_W-1:0]     slot_cnt;
  logic [GRID_W-1:0]    cur_grid, nxt_grid;
  logic                 slot_first;
  logic [LIM_W-1:0]     lim_reg, lim_act;
  logic [SEG_W-1:0]     seg_hold;
  logic [NUM_GRIDS-1:0] grid_hot;
  logic [CNT_W-1:0]     shift_end;
  logic [AW:0]          rel;
  logic                 in_win;
  logic [AW-1:0]        bit_idx;
  logic [CODE_W-1:0]    cur_code;
  logic                 sel_bit;
  vfd_pins_t            pins_d, pins_q;

  vfd_slot_timer #(
    .SLOT_CYCLES(SLOT_CYCLES), .NUM_GRIDS(NUM_GRIDS), .CNT_W(CNT_W), .GRID_W(GRID_W)
  ) timer_i (
    .clk(clk), .rst_n(rst_n), .slot_cnt(slot_cnt), .cur_grid(cur_grid),
    .nxt_grid(nxt_grid), .slot_first(slot_first)
  );

  assign seg_grid = nxt_grid;

  // Limit register with clamp, and the per-slot shadow copy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_reg <= LIM_MAX;
    else if (lim_we) lim_reg <= (lim_val > LIM_MAX) ? LIM_MAX : lim_val;
  end

  // Slot-start capture of limit, segment data and grid select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_act  <= LIM_MAX;
      seg_hold <= '0;
      grid_hot <= '0;
    end else if (slot_first) begin
      lim_act  <= lim_reg;
      seg_hold <= seg_data;
      grid_hot <= NUM_GRIDS'(1) << nxt_grid;
    end
  end

  always_comb begin
    shift_end = CNT_W'(SHIFT_START) + CNT_W'({lim_act, 1'b0}) + CNT_W'(2);
    in_win    = (slot_cnt >= CNT_W'(SHIFT_START)) && (slot_cnt < shift_end);
    rel       = (AW+1)'(slot_cnt - CNT_W'(SHIFT_START));
    bit_idx   = rel[AW:1];
  end

  vfd_map_ram #(.DEPTH(MAX_BITS), .AW(AW)) map_i (
    .clk(clk), .rst_n(rst_n), .wr_en(map_we), .wr_addr(map_addr), .wr_code(map_code),
    .rd_addr(bit_idx), .rd_code(cur_code)
  );

  vfd_src_select #(.SEG_W(SEG_W), .NUM_GRIDS(NUM_GRIDS)) sel_i (
    .seg_hold(seg_hold), .grid_hot(grid_hot), .code(cur_code), .bit_out(sel_bit)
  );

  // Pin generation: data set in the low phase, clock high in the odd phase.
  always_comb begin
    pins_d.sclk  = in_win && rel[0];
    if (!in_win)      pins_d.dout = 1'b0;
    else if (!rel[0]) pins_d.dout = sel_bit;
    else              pins_d.dout = pins_q.dout;
    pins_d.load  = (slot_cnt == CNT_W'(LOAD_START)) || (slot_cnt == CNT_W'(LOAD_START + 1));
    pins_d.blank = (slot_cnt >= CNT_W'(BLANK_START));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= pins_d;
  end

  assign vfd_sclk  = pins_q.sclk;
  assign vfd_dout  = pins_q.dout;
  assign vfd_load  = pins_q.load;
  assign vfd_blank = pins_q.blank;

  AST_SCLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vfd_sclk |=> !vfd_sclk); // R2
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vfd_sclk |-> $stable(vfd_dout)); // R3
  AST_LIMIT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    lim_reg <= LIM_MAX); // R5
  AST_QUIET_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    vfd_blank |-> (!vfd_sclk && !vfd_dout)); // R7
  AST_LOAD_INSIDE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    vfd_load |-> vfd_blank); // R8
  AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (vfd_load && $past(vfd_load)) |=> !vfd_load); // R8
endmodule

// File: tb/vfd_mux_shifter_tb_top.sv
`timescale 1ns/1ps
module vfd_mux_shifter_tb_top;
  localparam int NG = 8;
  localparam int SW = 40;

  typedef struct packed {
    logic [7:0] lim;
    logic [7:0] exp_m;
    logic [1:0] mode;
  } vec_t;

  // limit written, limit expected in effect, map pattern
  localparam vec_t VECS [6] = '{
    '{8'h79, 8'd121, 2'd0},
    '{8'h00, 8'd0,   2'd0},
    '{8'hFF, 8'd121, 2'd2},
    '{8'h7A, 8'd121, 2'd3},
    '{8'h0F, 8'd15,  2'd1},
    '{8'h78, 8'd120, 2'd2}
  };

  logic clk = 0, rst_n = 0;
  logic map_we = 0, lim_we = 0;
  logic [6:0] map_addr = '0, map_code = '0;
  logic [7:0] lim_val = '0;
  logic [2:0] seg_grid;
  logic [SW-1:0] seg_data;
  logic vfd_sclk, vfd_dout, vfd_load, vfd_blank;

  int checks = 0, errors = 0;
  int cyc_cnt = 0;

  int cap_nb, cap_g, cap_bad, cap_t;
  logic [121:0] cap_bits;

  always #10 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic logic [SW-1:0] seg_of(int g);
    logic [SW-1:0] v;
    for (int k = 0; k < SW; k++) v[k] = (((k * 3 + g * 5) % 7) < 3);
    return v;
  endfunction

  assign seg_data = seg_of(int'(seg_grid));

  function automatic logic [6:0] code_for(int mode, int i);
    case (mode)
      0: return (i < 48) ? 7'(i) : ((i % 2 == 1) ? 7'h7F : 7'd100);
      1: return 7'h7F;
      2: return 7'((i * 7 + 3) % 48);
      default: return 7'(40 + i % 8);
    endcase
  endfunction

  function automatic logic [121:0] exp_bits(int mode, int g, int nb);
    logic [121:0] v;
    logic [SW-1:0] s;
    int c;
    v = '0;
    s = seg_of(g);
    for (int i = 0; i < nb; i++) begin
      c = int'(code_for(mode, i));
      if (c == 127)         v[i] = 1'b0;
      else if (c < SW)      v[i] = s[c];
      else if (c < SW + NG) v[i] = ((c - SW) == g);
      else                  v[i] = 1'b0;
    end
    return v;
  endfunction

  vfd_mux_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_addr(map_addr), .map_code(map_code),
    .lim_we(lim_we), .lim_val(lim_val), .seg_grid(seg_grid), .seg_data(seg_data),
    .vfd_sclk(vfd_sclk), .vfd_dout(vfd_dout), .vfd_load(vfd_load), .vfd_blank(vfd_blank)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic write_lim(input logic [7:0] v);
    @(negedge clk); lim_we = 1; lim_val = v;
    @(negedge clk); lim_we = 0;
  endtask

  task automatic load_map(input int mode);
    for (int i = 0; i < 122; i++) begin
      @(negedge clk); map_we = 1; map_addr = 7'(i); map_code = code_for(mode, i);
    end
    @(negedge clk); map_we = 0;
  endtask

  // Capture one slot's stream up to the load pulse.
  task automatic capture_slot(input bit sync);
    int cyc, last_rise;
    logic prev_s, prev_d;
    if (sync) begin
      do @(negedge clk); while (!vfd_blank);
      do @(negedge clk); while (vfd_blank);
    end
    cap_nb = 0; cap_bits = '0; cap_bad = 0; cyc = 0; last_rise = -1;
    prev_s = vfd_sclk; prev_d = vfd_dout;
    while (!vfd_load) begin
      @(negedge clk);
      cyc++;
      if (vfd_sclk && !prev_s) begin
        if (cap_nb < 122) cap_bits[cap_nb] = vfd_dout;
        if (last_rise >= 0 && cyc - last_rise != 2) cap_bad++;
        last_rise = cyc;
        cap_nb++;
      end
      if (vfd_sclk && prev_s) cap_bad++;
      if (vfd_sclk && vfd_dout != prev_d) cap_bad++;
      prev_s = vfd_sclk; prev_d = vfd_dout;
    end
    if (vfd_sclk || vfd_dout) cap_bad++;
    cap_g = int'(seg_grid);
    cap_t = cyc_cnt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    int g0, t0, nb0, hi, lo, ld_off, ld_w, k;
    logic [121:0] b0;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk({vfd_sclk, vfd_dout, vfd_load, vfd_blank} == 4'b0, "R9 pins in reset",
        {vfd_sclk, vfd_dout, vfd_load, vfd_blank}, 0);
    chk(seg_grid == 3'd1, "R9 seg_grid in reset", seg_grid, 1);
    rst_n = 1;
    @(negedge clk);
    chk({vfd_sclk, vfd_dout, vfd_load, vfd_blank} == 4'b0, "R9 pins after reset",
        {vfd_sclk, vfd_dout, vfd_load, vfd_blank}, 0);

    // Vector table: R1 R2 R3 R4 R5 R6
    foreach (VECS[r]) begin
      write_lim(VECS[r].lim);
      load_map(int'(VECS[r].mode));
      capture_slot(1'b1);
      capture_slot(1'b1);
      g0 = cap_g; t0 = cap_t; nb0 = cap_nb; b0 = cap_bits;
      chk(nb0 == int'(VECS[r].exp_m) + 1, "R4 R5 bit count", nb0, int'(VECS[r].exp_m) + 1);
      chk(b0 == exp_bits(int'(VECS[r].mode), g0, nb0), "R6 mapped bits", b0,
          exp_bits(int'(VECS[r].mode), g0, nb0));
      chk(cap_bad == 0, "R2 R3 clock and data timing", cap_bad, 0);
      capture_slot(1'b1);
      chk(cap_g == (g0 + 1) % NG, "R1 grid order", cap_g, (g0 + 1) % NG);
      chk(cap_t - t0 == 400, "R1 slot length", cap_t - t0, 400);
      chk(cap_bits == exp_bits(int'(VECS[r].mode), cap_g, cap_nb), "R6 mapped bits next grid",
          cap_bits, exp_bits(int'(VECS[r].mode), cap_g, cap_nb));
    end

    // R7 R8: blank and load placement
    do @(negedge clk); while (vfd_blank);
    do @(negedge clk); while (!vfd_blank);
    hi = 1; ld_off = -1; ld_w = 0; k = 0;
    forever begin
      @(negedge clk); k++;
      if (vfd_load && ld_off < 0) ld_off = k;
      if (vfd_load) ld_w++;
      if (!vfd_blank) break;
      hi++;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (vfd_blank) break;
      lo++;
    end
    chk(hi == 25, "R7 blank high length", hi, 25);
    chk(lo == 375, "R7 blank low length", lo, 375);
    chk(ld_off == 1, "R8 load offset in blank", ld_off, 1);
    chk(ld_w == 2, "R8 load width", ld_w, 2);

    // R5: a limit written mid-slot waits for the next slot
    do @(negedge clk); while (vfd_blank);
    write_lim(8'h03);
    capture_slot(1'b0);
    chk(cap_nb == 121, "R5 current slot keeps old limit", cap_nb, 121);
    capture_slot(1'b1);
    chk(cap_nb == 4, "R5 next slot uses new limit", cap_nb, 4);

    // R9 R5 R6: reset in mid-run restores limit and map
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk({vfd_sclk, vfd_dout, vfd_load, vfd_blank} == 4'b0 && seg_grid == 3'd1,
        "R9 mid-run reset", {vfd_sclk, vfd_dout, vfd_load, vfd_blank, seg_grid}, 1);
    rst_n = 1;
    capture_slot(1'b1);
    chk(cap_nb == 122, "R5 limit back to 0x79", cap_nb, 122);
    chk(cap_bits == '0, "R6 map back to off codes", cap_bits, 0);
    chk(cap_g == 2, "R1 first full slot after reset", cap_g, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule